// File: doc/BRIEF.md
# Embedded Controller Host Port

This block lets a host reach a 256-byte internal register space one byte at a time through a three-register I/O window. The host never addresses an internal register directly. It writes a command byte, then any address and data bytes the command needs, and waits on two handshake flags between steps. The input-full flag is raised for every byte the host writes and drops once the internal sequencer has taken that byte. The output-full flag is raised when a result byte is waiting in the data port.

The back side is a plain synchronous register-bus master. It issues single-cycle read and write strobes with an 8-bit address, and read data returns one clock after the read strobe. The block also has a burst-mode flag and a small set of pending events. The host drains those events one at a time with a query command. An interrupt-control byte is stored so the host can read it back, but it routes nothing.

Top module: `ec_host_port`

## Requirements
- R1: Host window offsets on `hostAddr`: 0x0 is the data port, 0x4 is status on read and command on write, and 0x8 is an interrupt-control byte that can be written and read back. Every other offset reads 0x00 and ignores writes.
- R2: Status byte fields: bit0 is output-full, bit1 is input-full, bit3 is 1 when the most recent host byte went to the command port and 0 when it went to the data port, bit4 is burst mode, and bit5 is 1 while any event is pending. Bits 2, 6 and 7 read 0. Everything reads 0 after reset.
- R3: A host write to offset 0x0 or 0x4 sets input-full on the next cycle. Input-full clears within CONSUME_LAT+1 cycles of that write when no further byte arrives.
- R4: Command 0x80 followed by an address byte issues exactly one bus read of that address. The returned value is then placed in the data port and output-full is set.
- R5: Command 0x81 followed by an address byte and a data byte issues exactly one bus write of that data to that address.
- R6: A host read of the data port clears output-full.
- R7: Command 0x82 sets status bit4, places 0x90 in the data port and sets output-full. Command 0x83 clears bit4 and does not set output-full.
- R8: Command 0x84 places k+1 in the data port, where k is the lowest pending event index on `evtSet`, and clears event k. With no event pending it places 0x00. Output-full is set in both cases.
- R9: A command byte other than 0x80 to 0x84 is dropped. It causes no bus access and does not set output-full, and a data byte sent after it is ignored.
- R10: A command byte written in the middle of a read or write sequence abandons that sequence and starts the new command. The abandoned sequence causes no bus access.
- R11: A data-port byte written when no command is waiting for one causes no bus access and does not set output-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 4 | Host window offset |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte for `hostAddr` |
| evtSet | input | NUM_EVENTS | One-cycle pulses that raise pending events |
| regAddr | output | 8 | Back-side register address |
| regWr | output | 1 | Back-side write strobe |
| regRd | output | 1 | Back-side read strobe |
| regWdata | output | 8 | Back-side write data |
| regRdata | input | 8 | Back-side read data, valid one cycle after `regRd` |

## Verification
The hardest state to reach from the ports is a sequence that is abandoned partway through. An address byte has already been latched, and a write is waiting only for its data byte, when a fresh command arrives. The stimulus reaches this state by issuing a write command and an address, then sending a read command and a new address instead of the data byte. The bench confirms that the bus sees only the read, and that the old target register still holds its earlier value. Event queries are reached by pulsing two event lines in one cycle and draining them in order.

// File: rtl/ec_pkg.sv
package ec_pkg;
  localparam logic [3:0] OFS_DATA = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_ICR  = 4'h8;

  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;
  localparam logic [7:0] BURST_ACK    = 8'h90;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_WR_ADDR, S_WR_DATA, S_RD_WAIT
  } seqState_t;

  typedef enum logic [1:0] {OUT_BUS, OUT_BURST, OUT_QUERY} outSel_t;

  typedef struct packed {
    logic    consume;
    logic    loadOut;
    outSel_t outSel;
    logic    burstOn;
    logic    burstOff;
    logic    latchAddr;
    logic    busRd;
    logic    busWr;
  } ecStrobe_t;
endpackage

// File: rtl/ec_ctrl.sv
module ec_ctrl
  import ec_pkg::*;
#(
  parameter int CONSUME_LAT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ibf,
  input  logic       byteWr,
  input  logic [7:0] inByte,
  input  logic       inIsCmd,
  output ecStrobe_t  strobe
);
  localparam int CW = $clog2(CONSUME_LAT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CONSUME_LAT - 1);

  logic [CW-1:0] waitCnt;
  seqState_t     state, nextState;
  logic          ready;

  assign ready = ibf && !byteWr && (waitCnt >= CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      state   <= S_IDLE;
    end else begin
      state <= nextState;
      if (byteWr)
        waitCnt <= '0;
      else if (ibf && waitCnt < CNT_LAST)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (state == S_RD_WAIT) begin
      strobe.loadOut = 1'b1;
      strobe.outSel  = OUT_BUS;
      nextState      = S_IDLE;
    end else if (ready) begin
      strobe.consume = 1'b1;
      if (inIsCmd) begin
        nextState = S_IDLE;
        case (inByte)
          OP_READ:  nextState = S_RD_ADDR;
          OP_WRITE: nextState = S_WR_ADDR;
          OP_BURST_ON: begin
            strobe.burstOn = 1'b1;
            strobe.loadOut = 1'b1;
            strobe.outSel  = OUT_BURST;
          end
          OP_BURST_OFF: strobe.burstOff = 1'b1;
          OP_QUERY: begin
            strobe.loadOut = 1'b1;
            strobe.outSel  = OUT_QUERY;
          end
          default: ;
        endcase
      end else begin
        case (state)
          S_RD_ADDR: begin
            strobe.busRd = 1'b1;
            nextState    = S_RD_WAIT;
          end
          S_WR_ADDR: begin
            strobe.latchAddr = 1'b1;
            nextState        = S_WR_DATA;
          end
          S_WR_DATA: begin
            strobe.busWr = 1'b1;
            nextState    = S_IDLE;
          end
          default: nextState = S_IDLE;
        endcase
      end
    end
  end

  // R4: a bus read is always followed by loading its result
  p_read_loads_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busRd |=> (strobe.loadOut && strobe.outSel == OUT_BUS));

  // R9: an unrecognised command leaves the sequencer idle
  p_unknown_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && inIsCmd && (inByte < OP_READ || inByte > OP_QUERY))
      |=> (state == S_IDLE));
endmodule

// File: rtl/ec_dpath.sv
module ec_dpath
  import ec_pkg::*;
#(
  parameter int NUM_EVENTS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            hostAddr,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  input  logic [NUM_EVENTS-1:0] evtSet,
  input  ecStrobe_t             strobe,
  output logic                  ibf,
  output logic                  byteWr,
  output logic [7:0]            inByte,
  output logic                  inIsCmd,
  output logic [7:0]            regAddr,
  output logic                  regWr,
  output logic                  regRd,
  output logic [7:0]            regWdata,
  input  logic [7:0]            regRdata
);
  localparam int IW = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  logic                  obf, burst;
  logic [7:0]            outData, icr, addrReg, qByte, outNext;
  logic [NUM_EVENTS-1:0] pending, clrMask;
  logic                  qHit;
  logic [IW-1:0]         qIdx;

  assign byteWr = hostWr && (hostAddr == OFS_DATA || hostAddr == OFS_CMD);

  always_comb begin
    qHit = 1'b0;
    qIdx = '0;
    for (int i = NUM_EVENTS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        qHit = 1'b1;
        qIdx = IW'(i);
      end
    end
  end

  assign qByte = qHit ? 8'(qIdx) + 8'd1 : 8'h00;

  always_comb begin
    clrMask = '0;
    if (strobe.loadOut && strobe.outSel == OUT_QUERY && qHit)
      clrMask[qIdx] = 1'b1;
  end

  always_comb begin
    case (strobe.outSel)
      OUT_BURST: outNext = BURST_ACK;
      OUT_QUERY: outNext = qByte;
      default:   outNext = regRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibf <= 1'b0; obf <= 1'b0; burst <= 1'b0; inIsCmd <= 1'b0;
      inByte <= '0; outData <= '0; icr <= '0; addrReg <= '0; pending <= '0;
    end else begin
      if (byteWr) begin
        ibf     <= 1'b1;
        inByte  <= hostWdata;
        inIsCmd <= (hostAddr == OFS_CMD);
      end else if (strobe.consume) begin
        ibf <= 1'b0;
      end
      if (hostWr && hostAddr == OFS_ICR) icr <= hostWdata;
      if (strobe.loadOut) begin
        obf     <= 1'b1;
        outData <= outNext;
      end else if (hostRd && hostAddr == OFS_DATA) begin
        obf <= 1'b0;
      end
      if (strobe.burstOn)       burst <= 1'b1;
      else if (strobe.burstOff) burst <= 1'b0;
      if (strobe.latchAddr) addrReg <= inByte;
      pending <= (pending & ~clrMask) | evtSet;
    end
  end

  always_comb begin
    case (hostAddr)
      OFS_DATA: hostRdata = outData;
      OFS_CMD:  hostRdata = {2'b00, |pending, burst, inIsCmd, 1'b0, ibf, obf};
      OFS_ICR:  hostRdata = icr;
      default:  hostRdata = 8'h00;
    endcase
  end

  assign regAddr  = strobe.busWr ? addrReg : inByte;
  assign regWdata = inByte;
  assign regWr    = strobe.busWr;
  assign regRd    = strobe.busRd;

  p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteWr |=> ibf);

  p_obf_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == OFS_DATA && !strobe.loadOut) |=> !obf);

  p_burst_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadOut && strobe.outSel == OUT_BURST)
      |=> (outData == BURST_ACK && burst && obf));

  p_query_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadOut && strobe.outSel == OUT_QUERY)
      |=> (outData == $past(qByte) && obf));

  p_bus_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regRd, regWr}));
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_pkg::*;
#(
  parameter int CONSUME_LAT = 3,
  parameter int NUM_EVENTS  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3:0]            hostAddr,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  input  logic [NUM_EVENTS-1:0] evtSet,
  output logic [7:0]            regAddr,
  output logic                  regWr,
  output logic                  regRd,
  output logic [7:0]            regWdata,
  input  logic [7:0]            regRdata
);
  ecStrobe_t  strobe;
  logic       ibf, byteWr, inIsCmd;
  logic [7:0] inByte;

  ec_ctrl #(.CONSUME_LAT(CONSUME_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .ibf(ibf), .byteWr(byteWr),
    .inByte(inByte), .inIsCmd(inIsCmd), .strobe(strobe)
  );

  ec_dpath #(.NUM_EVENTS(NUM_EVENTS)) uDpath (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .evtSet(evtSet), .strobe(strobe), .ibf(ibf), .byteWr(byteWr),
    .inByte(inByte), .inIsCmd(inIsCmd), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata)
  );
endmodule

// File: tb/ec_host_port_test.sv
module ec_host_port_test;
  localparam int LAT = 3;
  localparam int NEV = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [3:0]     hostAddr = '0;
  logic           hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]     hostWdata = '0, hostRdata;
  logic [NEV-1:0] evtSet = '0;
  logic [7:0]     regAddr, regWdata, regRdata;
  logic           regWr, regRd;

  logic [7:0] mem [256];
  int rdCount = 0, wrCount = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ec_host_port #(.CONSUME_LAT(LAT), .NUM_EVENTS(NEV)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .evtSet(evtSet), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  always_ff @(posedge clk) begin
    if (regWr) begin mem[regAddr] <= regWdata; wrCount <= wrCount + 1; end
    if (regRd) begin regRdata <= mem[regAddr]; rdCount <= rdCount + 1; end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(posedge clk); #1 hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(posedge clk); #1 hostRd = 1'b0;
  endtask

  task automatic waitFlag(input int bitPos, input bit level, output int polls);
    logic [7:0] s;
    polls = 0;
    for (int i = 0; i < 50; i++) begin
      hostRead(4'h4, s);
      polls++;
      if (s[bitPos] == level) break;
    end
  endtask

  task automatic sendByte(input logic [3:0] a, input logic [7:0] d);
    int p;
    hostWrite(a, d);
    waitFlag(1, 1'b0, p);
  endtask

  task automatic ecWrite(input logic [7:0] a, input logic [7:0] d);
    sendByte(4'h4, 8'h81); sendByte(4'h0, a); sendByte(4'h0, d);
  endtask

  task automatic ecRead(input logic [7:0] a, output logic [7:0] d);
    int p;
    sendByte(4'h4, 8'h80); sendByte(4'h0, a);
    waitFlag(0, 1'b1, p);
    hostRead(4'h0, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    hostRead(4'h4, v); checkEq("R2 reset status", v, 8'h00);
    hostRead(4'h0, v); checkEq("R1 reset data", v, 8'h00);
    hostRead(4'h8, v); checkEq("R1 reset icr", v, 8'h00);
  endtask

  task automatic t_window;
    logic [7:0] v;
    hostWrite(4'h8, 8'h5A);
    hostRead(4'h8, v); checkEq("R1 icr readback", v, 8'h5A);
    hostWrite(4'hC, 8'hFF);
    hostRead(4'hC, v); checkEq("R1 unused offset", v, 8'h00);
    hostRead(4'h4, v); checkEq("R1 unused write no ibf", v[1], 0);
  endtask

  task automatic t_latency;
    int p;
    logic [7:0] v;
    hostWrite(4'h4, 8'h83);
    hostRead(4'h4, v);
    checkEq("R3 ibf set after write", v[1], 1);
    checkEq("R2 cmd bit after command", v[3], 1);
    waitFlag(1, 1'b0, p);
    checkEq("R3 ibf cleared in time", (p + 1 <= LAT + 1) ? 1 : 0, 1);
  endtask

  task automatic t_rw;
    logic [7:0] v;
    int r0, w0;
    r0 = rdCount; w0 = wrCount;
    ecWrite(8'h12, 8'hA5);
    checkEq("R5 one bus write", wrCount - w0, 1);
    checkEq("R5 stored data", mem[8'h12], 8'hA5);
    hostRead(4'h4, v); checkEq("R2 cmd bit after data", v[3], 0);
    ecWrite(8'hFF, 8'h3C);
    ecRead(8'h12, v); checkEq("R4 read value a", v, 8'hA5);
    ecRead(8'hFF, v); checkEq("R4 read value b", v, 8'h3C);
    checkEq("R4 bus reads", rdCount - r0, 2);
    hostRead(4'h4, v); checkEq("R6 obf cleared by data read", v[0], 0);
  endtask

  task automatic t_burst;
    logic [7:0] v;
    int p;
    sendByte(4'h4, 8'h82);
    waitFlag(0, 1'b1, p);
    hostRead(4'h4, v); checkEq("R7 burst bit on", v[4], 1);
    hostRead(4'h0, v); checkEq("R7 burst ack", v, 8'h90);
    sendByte(4'h4, 8'h83);
    hostRead(4'h4, v);
    checkEq("R7 burst bit off", v[4], 0);
    checkEq("R7 no obf on disable", v[0], 0);
  endtask

  task automatic t_query;
    logic [7:0] v;
    int p;
    @(negedge clk); evtSet = 8'b0010_0100;
    @(negedge clk); evtSet = '0;
    hostRead(4'h4, v); checkEq("R2 event pending bit", v[5], 1);
    sendByte(4'h4, 8'h84); waitFlag(0, 1'b1, p);
    hostRead(4'h0, v); checkEq("R8 first query", v, 8'h03);
    sendByte(4'h4, 8'h84); waitFlag(0, 1'b1, p);
    hostRead(4'h0, v); checkEq("R8 second query", v, 8'h06);
    sendByte(4'h4, 8'h84); waitFlag(0, 1'b1, p);
    hostRead(4'h0, v); checkEq("R8 empty query", v, 8'h00);
    hostRead(4'h4, v); checkEq("R8 pending cleared", v[5], 0);
  endtask

  task automatic t_unknown;
    logic [7:0] v;
    int r0, w0;
    r0 = rdCount; w0 = wrCount;
    sendByte(4'h4, 8'h55);
    sendByte(4'h0, 8'h10);
    repeat (4) @(negedge clk);
    checkEq("R9 no bus access", (rdCount - r0) + (wrCount - w0), 0);
    hostRead(4'h4, v); checkEq("R9 no obf", v[0], 0);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    int w0;
    ecWrite(8'h20, 8'h11);
    ecWrite(8'h21, 8'h77);
    w0 = wrCount;
    sendByte(4'h4, 8'h81); sendByte(4'h0, 8'h20);
    ecRead(8'h21, v);
    checkEq("R10 new command result", v, 8'h77);
    checkEq("R10 abandoned write absent", wrCount - w0, 0);
    ecRead(8'h20, v); checkEq("R10 old target intact", v, 8'h11);
  endtask

  task automatic t_stray;
    logic [7:0] v;
    int r0, w0;
    r0 = rdCount; w0 = wrCount;
    sendByte(4'h0, 8'h42);
    repeat (4) @(negedge clk);
    checkEq("R11 stray byte no bus", (rdCount - r0) + (wrCount - w0), 0);
    hostRead(4'h4, v); checkEq("R11 stray byte no obf", v[0], 0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    regRdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_window();
    t_latency();
    t_rw();
    t_burst();
    t_query();
    t_unknown();
    t_abort();
    t_stray();
    finishRun();
  end
endmodule